// File: doc/BRIEF.md
# Type-0 Configuration Address Translator

This block sits behind a CPU-visible window reserved for configuration cycles to devices on the first PCI bus segment. A CPU access supplies a 16-bit byte offset within the window; the block joins it with a 16-bit upper field taken from a map-configuration value, so the pair forms one 32-bit intermediate configuration word. The upper part of that word carries a one-hot device select, and the block turns the position of its lowest set bit into a binary device number. It then builds a standard configuration address from the bus number, that device number, the function number and the dword-aligned register byte offset, with the enable bit at the top.

A translated access leaves as a single-cycle transaction pulse. The block then waits for a completion handshake before it takes the next CPU request, and returns read data trimmed to the access size. When the map value selects a type-1 request, nothing leaves the block and the CPU gets all ones. When the device select field is empty, a sticky error flag is raised instead of a transaction. Each issued transaction also pulses a strobe that clears the received-abort bits in the bridge's own status register.

Top module: `cfgx_top`

## Requirements
- R1: The intermediate word is {map_cfg[15:0], req_offset[15:0]}. Its bits [10:8] give the function number and its bits [7:2] give the register dword index. The register field is placed in txn_addr[7:2], and txn_addr[1:0] is 0.
- R2: The device number is the index of the lowest set bit of intermediate bits [31:11]. Field bit 0 (word bit 11) is device 0 and field bit 20 is device 20. Higher set bits are ignored.
- R3: txn_addr is {1'b1, 7'b0, bus_num[7:0], device[4:0], function[2:0], register[5:0], 2'b00}.
- R4: If map_cfg[16] is 1 when a request is accepted, no transaction is issued, err_flag does not change, and one cycle later rsp_valid and rsp_blocked are 1 with rsp_rdata equal to ones in its low 8*(req_size+1) bits. This applies to reads and writes alike.
- R5: If map_cfg[16] is 0 and intermediate bits [31:11] are all zero, no transaction is issued. One cycle later err_flag is set, and rsp_valid and rsp_error are 1 with rsp_rdata equal to the size mask of R4.
- R6: abort_clr pulses high in exactly the cycles in which txn_valid is high, and never for blocked or erroneous requests.
- R7: err_flag stays set until a cycle in which err_clr is 1. If err_clr and a new error occur in the same cycle, the flag stays set.
- R8: A request is accepted when req_valid and req_ready are both 1. txn_valid is a one-cycle pulse in the cycle after acceptance. req_ready is 0 from that cycle until the cycle after txn_done. txn_done has no effect while no transaction is outstanding.
- R9: The cycle after txn_done, rsp_valid is 1 and rsp_rdata equals txn_rdata masked to the accepted size. Blocked and erroneous requests leave req_ready at 1, so they can be issued back to back.
- R10: req_size is the byte count minus one (0 to 3). txn_byte_en has bit b set when req_offset[1:0] <= b <= req_offset[1:0] + req_size. txn_write and txn_wdata carry req_write and req_wdata.
- R11: After reset, req_ready is 1 and txn_valid, abort_clr, rsp_valid, rsp_blocked, rsp_error and err_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Translator can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Byte count minus one |
| req_offset | input | 16 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| map_cfg | input | 17 | [15:0] upper word field, [16] type-1 select |
| bus_num | input | 8 | Bus number placed in the address |
| txn_valid | output | 1 | One-cycle transaction pulse |
| txn_write | output | 1 | Transaction direction |
| txn_addr | output | 32 | Translated configuration address |
| txn_byte_en | output | 4 | Byte lanes of the access |
| txn_wdata | output | 32 | Transaction write data |
| txn_done | input | 1 | Transaction completion |
| txn_rdata | input | 32 | Data returned with txn_done |
| rsp_valid | output | 1 | Response to the CPU |
| rsp_blocked | output | 1 | Response to a type-1 request |
| rsp_error | output | 1 | Response to an empty device select |
| rsp_rdata | output | 32 | Read data returned to the CPU |
| err_flag | output | 1 | Sticky illegal-address flag |
| err_clr | input | 1 | Clears err_flag |
| abort_clr | output | 1 | Clears the received-abort status bits |

## Verification
The one-hot select is walked through every one of its 21 positions, and each position is placed in either half of the intermediate word, so a wrong device count or a wrong join of offset and map field shows up as an address mismatch. Patterns with several select bits set tell lowest-bit priority apart from highest-bit or OR decoding. Type-1 requests, empty selects, and empty selects with the type-1 bit also set tell the gating order apart. They also show the size-dependent all-ones mask for every size and lane. A long pseudo-random stream with varied completion delays, together with stray completions and a clear that lands in the same cycle as a new error, exercises the handshake and the sticky flag against a behavioural model on every clock.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int CFG_W     = 32;
  localparam int OFS_W     = CFG_W / 2;
  localparam int DATA_W    = 32;
  localparam int BUS_W     = 8;
  localparam int SEL_LSB   = 11;
  localparam int SEL_W     = CFG_W - SEL_LSB;
  localparam int DEV_W     = $clog2(SEL_W);
  localparam int FUN_W     = 3;
  localparam int LANES     = DATA_W / 8;
  localparam int SIZE_W    = $clog2(LANES);

  typedef enum logic {ST_IDLE, ST_WAIT} cfgx_state_e;

  // Ones in the low (szm1+1) bytes of a data word.
  function automatic logic [DATA_W-1:0] size_fill(input logic [SIZE_W-1:0] szm1);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < LANES; b++) begin
      m[b*8 +: 8] = (b <= int'(szm1)) ? 8'hFF : 8'h00;
    end
    return m;
  endfunction

  // Byte lanes touched by an access starting at lane with szm1+1 bytes.
  function automatic logic [LANES-1:0] lane_enables(input logic [SIZE_W-1:0] szm1,
                                                    input logic [SIZE_W-1:0] lane);
    logic [LANES-1:0] en;
    for (int b = 0; b < LANES; b++) begin
      en[b] = (b >= int'(lane)) && (b <= int'(lane) + int'(szm1));
    end
    return en;
  endfunction

  // Standard configuration address with the enable bit on top.
  function automatic logic [CFG_W-1:0] pack_cfg_addr(input logic [BUS_W-1:0] bus,
                                                     input logic [DEV_W-1:0] dev,
                                                     input logic [FUN_W-1:0] fun,
                                                     input logic [5:0]       dw);
    return {1'b1, 7'b0, bus, dev, fun, dw, 2'b00};
  endfunction

endpackage

// File: rtl/cfgx_lsb_find.sv
module cfgx_lsb_find #(
  parameter int W     = cfgx_pkg::SEL_W,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // clear_below[i] is 1 when no bit below i is set
  logic [W:0]   clear_below;
  logic [W-1:0] first_hit;

  assign clear_below[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign first_hit[i]     = vec[i] & clear_below[i];
    assign clear_below[i+1] = clear_below[i] & ~vec[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (first_hit[i]) idx = idx | IDX_W'(i);
    end
  end

  assign any = ~clear_below[W];

  // first_hit is one-hot or empty, and empty exactly when nothing is set
  always_comb begin
    a_single_hit_r2: assert ($onehot0(first_hit));
  end

endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
(
  input  logic [OFS_W-1:0]  offset,
  input  logic [OFS_W-1:0]  map_hi,
  input  logic [BUS_W-1:0]  bus,
  output logic [CFG_W-1:0]  addr,
  output logic [SIZE_W-1:0] lane,
  output logic              sel_empty
);
  logic [CFG_W-1:0] word;
  logic [SEL_W-1:0] sel;
  logic [DEV_W-1:0] dev;
  logic             sel_any;

  assign word = {map_hi, offset};
  assign sel  = word[CFG_W-1:SEL_LSB];
  assign lane = word[SIZE_W-1:0];

  cfgx_lsb_find #(.W(SEL_W), .IDX_W(DEV_W)) u_find (
    .vec (sel),
    .idx (dev),
    .any (sel_any)
  );

  assign sel_empty = ~sel_any;
  assign addr      = pack_cfg_addr(bus, dev, word[10:8], word[7:2]);

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              type1_sel,
  input  logic              sel_empty,
  input  logic [CFG_W-1:0]  dec_addr,
  input  logic [SIZE_W-1:0] dec_lane,
  output logic              txn_valid,
  output logic              txn_write,
  output logic [CFG_W-1:0]  txn_addr,
  output logic [LANES-1:0]  txn_byte_en,
  output logic [DATA_W-1:0] txn_wdata,
  input  logic              txn_done,
  input  logic [DATA_W-1:0] txn_rdata,
  output logic              rsp_valid,
  output logic              rsp_blocked,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err_flag,
  input  logic              err_clr,
  output logic              abort_clr
);
  cfgx_state_e      state;
  logic [SIZE_W-1:0] size_q;

  // Named events for the assertions
  logic accept;
  logic start_block;
  logic start_err;
  logic start_txn;
  logic finish_txn;

  assign req_ready   = (state == ST_IDLE);
  assign accept      = req_valid & req_ready;
  assign start_block = accept & type1_sel;
  assign start_err   = accept & ~type1_sel & sel_empty;
  assign start_txn   = accept & ~type1_sel & ~sel_empty;
  assign finish_txn  = (state == ST_WAIT) & txn_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      size_q      <= '0;
      txn_valid   <= 1'b0;
      txn_write   <= 1'b0;
      txn_addr    <= '0;
      txn_byte_en <= '0;
      txn_wdata   <= '0;
      rsp_valid   <= 1'b0;
      rsp_blocked <= 1'b0;
      rsp_error   <= 1'b0;
      rsp_rdata   <= '0;
      err_flag    <= 1'b0;
      abort_clr   <= 1'b0;
    end else begin
      txn_valid   <= 1'b0;
      abort_clr   <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_blocked <= 1'b0;
      rsp_error   <= 1'b0;

      if (err_clr)   err_flag <= 1'b0;
      if (start_err) err_flag <= 1'b1;

      if (start_block || start_err) begin
        rsp_valid   <= 1'b1;
        rsp_blocked <= start_block;
        rsp_error   <= start_err;
        rsp_rdata   <= size_fill(req_size);
      end

      if (start_txn) begin
        state       <= ST_WAIT;
        size_q      <= req_size;
        txn_valid   <= 1'b1;
        abort_clr   <= 1'b1;
        txn_write   <= req_write;
        txn_addr    <= dec_addr;
        txn_byte_en <= lane_enables(req_size, dec_lane);
        txn_wdata   <= req_wdata;
      end

      if (finish_txn) begin
        state     <= ST_IDLE;
        rsp_valid <= 1'b1;
        rsp_rdata <= txn_rdata & size_fill(size_q);
      end
    end
  end

  // R3: every issued address carries the enable bit and a dword-aligned register
  p_enable_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_addr[CFG_W-1] && txn_addr[1:0] == 2'b00 && txn_addr[30:24] == 7'd0));

  // R8: the transaction pulse lasts one cycle
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> !txn_valid);

  // R8: no new request is taken while a transaction is outstanding
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  // R6: the status clear strobe only rides along with an issued transaction
  p_abort_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_clr |-> txn_valid);

  // R5: a newly raised error comes with an error response and no transaction
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (rsp_error && rsp_valid && !txn_valid));

  // R4: a blocked response is a response and never an error
  p_blocked_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_blocked |-> (rsp_valid && !rsp_error && !txn_valid));

  // R7: a clear without a competing error empties the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !start_err) |=> !err_flag);

  // R9: a completion answers with a response and reopens the request side
  p_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finish_txn |=> (rsp_valid && req_ready && !rsp_blocked && !rsp_error));

endmodule

// File: rtl/cfgx_top.sv
module cfgx_top
  import cfgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [15:0]       req_offset,
  input  logic [31:0]       req_wdata,
  input  logic [16:0]       map_cfg,
  input  logic [7:0]        bus_num,
  output logic              txn_valid,
  output logic              txn_write,
  output logic [31:0]       txn_addr,
  output logic [3:0]        txn_byte_en,
  output logic [31:0]       txn_wdata,
  input  logic              txn_done,
  input  logic [31:0]       txn_rdata,
  output logic              rsp_valid,
  output logic              rsp_blocked,
  output logic              rsp_error,
  output logic [31:0]       rsp_rdata,
  output logic              err_flag,
  input  logic              err_clr,
  output logic              abort_clr
);
  logic [CFG_W-1:0]  dec_addr;
  logic [SIZE_W-1:0] dec_lane;
  logic              sel_empty;

  cfgx_decode u_decode (
    .offset    (req_offset),
    .map_hi    (map_cfg[OFS_W-1:0]),
    .bus       (bus_num),
    .addr      (dec_addr),
    .lane      (dec_lane),
    .sel_empty (sel_empty)
  );

  cfgx_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_wdata   (req_wdata),
    .type1_sel   (map_cfg[OFS_W]),
    .sel_empty   (sel_empty),
    .dec_addr    (dec_addr),
    .dec_lane    (dec_lane),
    .txn_valid   (txn_valid),
    .txn_write   (txn_write),
    .txn_addr    (txn_addr),
    .txn_byte_en (txn_byte_en),
    .txn_wdata   (txn_wdata),
    .txn_done    (txn_done),
    .txn_rdata   (txn_rdata),
    .rsp_valid   (rsp_valid),
    .rsp_blocked (rsp_blocked),
    .rsp_error   (rsp_error),
    .rsp_rdata   (rsp_rdata),
    .err_flag    (err_flag),
    .err_clr     (err_clr),
    .abort_clr   (abort_clr)
  );

endmodule

// File: tb/cfgx_top_bench.sv
module cfgx_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_offset = 16'd0;
  logic [31:0] req_wdata = 32'd0;
  logic [16:0] map_cfg = 17'd0;
  logic [7:0]  bus_num = 8'd0;
  logic        txn_valid;
  logic        txn_write;
  logic [31:0] txn_addr;
  logic [3:0]  txn_byte_en;
  logic [31:0] txn_wdata;
  logic        txn_done = 1'b0;
  logic [31:0] txn_rdata = 32'd0;
  logic        rsp_valid;
  logic        rsp_blocked;
  logic        rsp_error;
  logic [31:0] rsp_rdata;
  logic        err_flag;
  logic        err_clr = 1'b0;
  logic        abort_clr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgx_top u_cfgx_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
    .map_cfg(map_cfg), .bus_num(bus_num),
    .txn_valid(txn_valid), .txn_write(txn_write), .txn_addr(txn_addr),
    .txn_byte_en(txn_byte_en), .txn_wdata(txn_wdata),
    .txn_done(txn_done), .txn_rdata(txn_rdata),
    .rsp_valid(rsp_valid), .rsp_blocked(rsp_blocked), .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata), .err_flag(err_flag), .err_clr(err_clr),
    .abort_clr(abort_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int          m_busy;
  int          m_size;
  bit          m_txn, m_abort, m_rsp, m_blk, m_errr, m_err, m_wr;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [3:0]  m_be;

  function automatic logic [31:0] ones_for(input int sz);
    logic [31:0] v = 0;
    for (int b = 0; b <= sz; b++) v = v | (32'hFF << (8*b));
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_size = 0; m_txn = 0; m_abort = 0; m_rsp = 0;
      m_blk = 0; m_errr = 0; m_err = 0; m_wr = 0;
      m_addr = 0; m_wdata = 0; m_rdata = 0; m_be = 0;
    end else begin
      int busy_before;
      busy_before = m_busy;
      m_txn = 0; m_abort = 0; m_rsp = 0; m_blk = 0; m_errr = 0;
      if (err_clr) m_err = 0;
      if (busy_before == 0 && req_valid) begin
        logic [31:0] word;
        logic [20:0] sel;
        word = {map_cfg[15:0], req_offset};
        sel  = word >> 11;
        if (map_cfg[16]) begin
          m_rsp = 1; m_blk = 1; m_rdata = ones_for(int'(req_size));
        end else if (sel == 0) begin
          m_rsp = 1; m_errr = 1; m_err = 1; m_rdata = ones_for(int'(req_size));
        end else begin
          int dev;
          int lane;
          dev = -1;
          for (int k = 20; k >= 0; k--) if (sel[k]) dev = k;
          lane = int'(req_offset[1:0]);
          m_addr = 32'h8000_0000 | (32'(bus_num) << 16) | (32'(dev) << 11)
                   | (((word >> 8) & 32'h7) << 8) | (word & 32'hFC);
          m_be = 0;
          for (int b = 0; b < 4; b++)
            if (b >= lane && b <= lane + int'(req_size)) m_be[b] = 1'b1;
          m_txn = 1; m_abort = 1; m_busy = 1; m_size = int'(req_size);
          m_wr = req_write; m_wdata = req_wdata;
        end
      end else if (busy_before == 1 && txn_done) begin
        m_rsp = 1; m_busy = 0; m_rdata = txn_rdata & ones_for(m_size);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      chk("R8 req_ready", {31'd0, req_ready}, {31'd0, m_busy == 0});
      chk("R8 txn_valid", {31'd0, txn_valid}, {31'd0, m_txn});
      chk("R6 abort_clr", {31'd0, abort_clr}, {31'd0, m_abort});
      chk("R9 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rsp});
      chk("R4 rsp_blocked", {31'd0, rsp_blocked}, {31'd0, m_blk});
      chk("R5 rsp_error", {31'd0, rsp_error}, {31'd0, m_errr});
      chk("R7 err_flag", {31'd0, err_flag}, {31'd0, m_err});
      if (m_txn) begin
        chk("R3 txn_addr", txn_addr, m_addr);
        chk("R10 txn_byte_en", {28'd0, txn_byte_en}, {28'd0, m_be});
        chk("R10 txn_write", {31'd0, txn_write}, {31'd0, m_wr});
        chk("R10 txn_wdata", txn_wdata, m_wdata);
      end
      if (m_rsp) chk("R9 rsp_rdata", rsp_rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit wr, input logic [1:0] sz, input logic [15:0] off,
                       input logic [16:0] map, input logic [7:0] bus,
                       input logic [31:0] wd, input int dly, input logic [31:0] rd,
                       input logic [31:0] hand_addr);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_offset = off;
    map_cfg = map; bus_num = bus; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (m_busy == 1) begin
      if (hand_addr != 0) chk("R3 hand-computed address", txn_addr, hand_addr);
      repeat (dly) @(negedge clk);
      txn_done = 1; txn_rdata = rd;
      @(negedge clk);
      txn_done = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset state
    chk("R11 ready after reset", {31'd0, req_ready}, 32'd1);
    chk("R11 txn_valid after reset", {31'd0, txn_valid}, 32'd0);
    chk("R11 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R11 err_flag after reset", {31'd0, err_flag}, 32'd0);
    chk("R11 abort_clr after reset", {31'd0, abort_clr}, 32'd0);

    // R1 R2 R3: hand example, select bit in map half, function 1, register 0x34
    issue(0, 2'd3, 16'h0134, 17'h00002, 8'h03, 0, 1, 32'hCAFE_F00D, 32'h8003_3134);
    // R2: two select bits, lowest wins (device 0)
    issue(0, 2'd3, 16'h8800, 17'h00000, 8'h00, 0, 0, 32'h1234_5678, 32'h8000_0000);
    // R2: two map-half bits, device 5
    issue(1, 2'd1, 16'h0006, 17'h00003, 8'hA5, 32'hDEAD_BEEF, 2, 0, 32'h80A5_2804);

    // R2: walk every select position through both halves
    for (int k = 0; k < 21; k++) begin
      int p;
      logic [15:0] off;
      logic [16:0] map;
      p = k + 11;
      off = (p < 16) ? (16'h1 << p) | 16'h05FC : 16'h07A8;
      map = (p < 16) ? 17'h0 : (17'h1 << (p - 16));
      issue(k[0], 2'(k), off, map, 8'(k * 7), 32'(k), k % 3, 32'hFFFF_0000 | 32'(k), 0);
    end

    // R4: type-1 select, every size, reads and writes, back to back
    for (int s = 0; s < 4; s++) begin
      issue(0, 2'(s), 16'h4000, 17'h10001, 8'h01, 0, 0, 0, 0);
      issue(1, 2'(s), 16'h0800, 17'h10000, 8'h01, 32'h55, 0, 0, 0);
    end
    @(negedge clk);
    chk("R4 flag untouched by type-1", {31'd0, err_flag}, 32'd0);

    // R5: empty select, and R4 priority over R5 when both hold
    issue(0, 2'd1, 16'h07FC, 17'h10000, 8'h00, 0, 0, 0, 0);
    @(negedge clk);
    chk("R4 type-1 wins over empty select", {31'd0, err_flag}, 32'd0);
    issue(0, 2'd2, 16'h07FC, 17'h00000, 8'h00, 0, 0, 0, 0);
    @(negedge clk);
    chk("R5 empty select raises flag", {31'd0, err_flag}, 32'd1);
    // R7: sticky over a good transaction, then cleared
    issue(0, 2'd0, 16'h0800, 17'h0, 8'h00, 0, 1, 32'h0000_00AA, 0);
    chk("R7 flag sticky", {31'd0, err_flag}, 32'd1);
    err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
    chk("R7 flag cleared", {31'd0, err_flag}, 32'd0);
    // R7: clear and new error in the same cycle, set wins
    while (!req_ready) @(negedge clk);
    err_clr = 1; req_valid = 1; req_size = 0; req_offset = 16'h0000; map_cfg = 17'h0;
    @(negedge clk);
    err_clr = 0; req_valid = 0;
    @(negedge clk);
    chk("R7 set wins over clear", {31'd0, err_flag}, 32'd1);
    err_clr = 1; @(negedge clk); err_clr = 0;

    // R8: stray completion while idle has no effect
    txn_done = 1; txn_rdata = 32'h1111_1111; @(negedge clk); txn_done = 0;
    chk("R8 stray done ignored", {31'd0, rsp_valid}, 32'd0);
    // R8 R9: long wait keeps ready low
    issue(0, 2'd3, 16'h1000, 17'h0, 8'h10, 0, 6, 32'h8765_4321, 0);

    // pseudo-random sweep
    lfsr = 32'hACE1_2357;
    for (int n = 0; n < 400; n++) begin
      logic [16:0] map;
      logic [15:0] off;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      map = {(lfsr[2:0] == 3'd0), lfsr[31:16] & ((lfsr[5:3] == 3'd0) ? 16'h0 : 16'hFFFF)};
      off = lfsr[15:0] ^ 16'h5A5A;
      if (lfsr[8:6] == 3'd0) begin off = off & 16'h07FF; map[15:0] = 0; end
      if (lfsr[12:9] == 4'd0) err_clr = 1;
      issue(lfsr[13], lfsr[15:14], off, map, lfsr[23:16], ~lfsr, int'(lfsr[26:25]),
            {lfsr[7:0], lfsr[31:8]}, 0);
      err_clr = 0;
    end
    repeat (3) @(negedge clk);

    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule